// File: doc/BRIEF.md
# Alternate-Bank Byte Pointer Unit

This block owns a 16-bit pointer into a second 64 KB memory bank that holds compiled byte-code. It never addresses the main bank. A small command port stands in for the processor decoder. Each accepted command does one of four things:

- load the byte under the pointer into the accumulator and step the pointer;
- store the accumulator under the pointer and step the pointer;
- exchange the pointer with the Y/A register pair;
- add a signed 8-bit displacement to the pointer.

The unit touches no status flags.

The bank splits into two regions. The top quarter, from address 0xC000 upward, is read-only non-volatile storage. The rest is RAM. A store aimed at the read-only region never reaches the memory port, but the pointer still steps. Memory is reached through a synchronous port: the read data is valid `MEM_LAT` cycles after the cycle in which `memRe` is high. A `busy` output holds off new commands while a load or store is still in progress.

Top module: `altbank_ptr_unit`

## Requirements
- R1: After reset the following are all low: `ptrOut` (0x0000), `busy`, `memRe`, `memWe`, `aWe` and `yWe`.
- R2: A load (`cmdOp`=0) raises `memRe` for exactly one cycle with `memAddr` equal to the pointer. With `MEM_LAT`=1, `aWe` pulses two cycles after that with `aOut` equal to the byte returned. The pointer ends one higher.
- R3: A store (`cmdOp`=1) to an address below 0xC000 raises `memWe` for exactly one cycle, with `memAddr` equal to the pointer and `memWdata` equal to `accIn`. The pointer ends one higher.
- R4: A store to an address of 0xC000 or above never raises `memWe`, and the pointer still advances by one.
- R5: An exchange (`cmdOp`=2) loads the pointer with {`accIn`,`yIn`}, with A as the high byte. In the next cycle it pulses `aWe` and `yWe` together, with `aOut` equal to the old pointer's high byte and `yOut` equal to its low byte.
- R6: An offset (`cmdOp`=3) sets the pointer to its old value plus `offsetIn` taken as a signed two's-complement byte, modulo 65536.
- R7: Stepping the pointer from 0xFFFF yields 0x0000.
- R8: While `busy` is high, `cmdValid` is ignored and the pointer does not change. A load holds `busy` for two cycles, a store for one, and an exchange or an offset for none.
- R9: `memRe` and `memWe` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe; taken when `busy` is low |
| cmdOp | input | 2 | 0 load, 1 store, 2 exchange, 3 offset |
| accIn | input | 8 | Current accumulator value |
| yIn | input | 8 | Current Y register value |
| offsetIn | input | 8 | Signed displacement for the offset command |
| busy | output | 1 | A memory access is in progress |
| ptrOut | output | 16 | Current pointer value |
| aOut | output | 8 | New accumulator value |
| aWe | output | 1 | Write strobe for `aOut` |
| yOut | output | 8 | New Y register value |
| yWe | output | 1 | Write strobe for `yOut` |
| memAddr | output | 16 | Alternate-bank address |
| memRe | output | 1 | Read request |
| memWe | output | 1 | Write request |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid `MEM_LAT` cycles after `memRe` |

## Verification
The hardest case to reach is a command arriving while a load is still waiting for its read data. The bench reaches it by holding an offset command on the port during the busy window. It then checks that the pointer shows only the load's single step and that the loaded byte is still correct.

Two other cases need specific pointer positions, and the bench sets each one with an exchange:
- the wrap from 0xFFFF to 0x0000;
- stores straddling the 0xBFFF/0xC000 region boundary.

All 256 offsets are swept from three base addresses, with each sum computed in the bench. The memory model returns a byte computed from the address, so every loaded value can be predicted.

// File: rtl/altbank_pkg.sv
package altbank_pkg;

  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_SWAP   = 2'd2,
    OP_OFFSET = 2'd3
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } state_e;

  // Strobes handed from control to datapath, one cycle each.
  typedef struct packed {
    logic issueRead;
    logic issueWrite;
    logic swapPtr;
    logic addOff;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/altbank_ctrl.sv
module altbank_ctrl
  import altbank_pkg::*;
#(
  parameter int MEM_LAT = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic [1:0] cmdOp,
  output strobe_t stb,
  output logic    busy,
  output logic    memRe
);

  localparam int CW = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
  localparam logic [CW-1:0] LAT_LAST = CW'(MEM_LAT - 1);

  state_e state, stateNext;
  logic [CW-1:0] waitCnt;
  opcode_e op;

  assign op    = opcode_e'(cmdOp);
  assign busy  = (state != ST_IDLE);
  assign memRe = (state == ST_READ);

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          case (op)
            OP_LOAD:   begin stb.issueRead  = 1'b1; stateNext = ST_READ;  end
            OP_STORE:  begin stb.issueWrite = 1'b1; stateNext = ST_WRITE; end
            OP_SWAP:   stb.swapPtr = 1'b1;
            OP_OFFSET: stb.addOff  = 1'b1;
            default:   ;
          endcase
        end
      end
      ST_READ:  stateNext = ST_WAIT;
      ST_WAIT: begin
        if (waitCnt == LAT_LAST) begin
          stb.capture = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      ST_WRITE: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_WAIT) waitCnt <= waitCnt + 1'b1;
      else                  waitCnt <= '0;
    end
  end

endmodule

// File: rtl/altbank_dpath.sv
module altbank_dpath
  import altbank_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] ROM_BASE = 16'hC000
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] yIn,
  input  logic [DW-1:0] offsetIn,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] ptrOut,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] aOut,
  output logic          aWe,
  output logic [DW-1:0] yOut,
  output logic          yWe
);

  localparam int EXT = AW - DW;

  logic [AW-1:0] ptr;
  logic [AW-1:0] offExt;
  logic          inRom;

  assign offExt = {{EXT{offsetIn[DW-1]}}, offsetIn};
  assign inRom  = (ptr >= ROM_BASE);
  assign ptrOut = ptr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= '0;
      memAddr  <= '0;
      memWe    <= 1'b0;
      memWdata <= '0;
      aOut     <= '0;
      aWe      <= 1'b0;
      yOut     <= '0;
      yWe      <= 1'b0;
    end else begin
      memWe <= stb.issueWrite & ~inRom;
      aWe   <= stb.capture | stb.swapPtr;
      yWe   <= stb.swapPtr;
      if (stb.issueRead || stb.issueWrite) begin
        memAddr <= ptr;
        ptr     <= ptr + 1'b1;
      end
      if (stb.issueWrite) memWdata <= accIn;
      if (stb.addOff) ptr <= ptr + offExt;
      if (stb.swapPtr) begin
        ptr  <= {accIn, yIn};
        aOut <= ptr[AW-1:DW];
        yOut <= ptr[DW-1:0];
      end
      if (stb.capture) aOut <= memRdata;
    end
  end

endmodule

// File: rtl/altbank_ptr_unit.sv
module altbank_ptr_unit
  import altbank_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] ROM_BASE = 16'hC000,
  parameter int MEM_LAT = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [1:0]    cmdOp,
  input  logic [DW-1:0] accIn,
  input  logic [DW-1:0] yIn,
  input  logic [DW-1:0] offsetIn,
  output logic          busy,
  output logic [AW-1:0] ptrOut,
  output logic [DW-1:0] aOut,
  output logic          aWe,
  output logic [DW-1:0] yOut,
  output logic          yWe,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata
);

  strobe_t stb;

  altbank_ctrl #(.MEM_LAT(MEM_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .stb(stb), .busy(busy), .memRe(memRe)
  );

  altbank_dpath #(.AW(AW), .DW(DW), .ROM_BASE(ROM_BASE)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .accIn(accIn), .yIn(yIn),
    .offsetIn(offsetIn), .memRdata(memRdata), .ptrOut(ptrOut),
    .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .aOut(aOut), .aWe(aWe), .yOut(yOut), .yWe(yWe)
  );

endmodule

// File: rtl/altbank_ptr_unit_chk.sv
module altbank_ptr_unit_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] ROM_BASE = 16'hC000
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic [AW-1:0] ptrOut,
  input logic [AW-1:0] memAddr,
  input logic          memRe,
  input logic          memWe,
  input logic          aWe,
  input logic          yWe
);

  a_r9_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  a_r4_no_rom_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr < ROM_BASE));

  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptrOut));

  a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memRe |=> !memRe);

  a_r3_write_pulse: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  a_r5_pair_write: assert property (@(posedge clk) disable iff (!rstN)
    yWe |-> aWe);

  a_r2_read_stalls: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> busy);

endmodule

bind altbank_ptr_unit altbank_ptr_unit_chk #(.AW(AW), .ROM_BASE(ROM_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .ptrOut(ptrOut), .memAddr(memAddr),
  .memRe(memRe), .memWe(memWe), .aWe(aWe), .yWe(yWe)
);

// File: tb/altbank_ptr_unit_bench.sv
module altbank_ptr_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [7:0]  accIn = 8'd0, yIn = 8'd0, offsetIn = 8'd0;
  logic        busy, aWe, yWe, memRe, memWe;
  logic [15:0] ptrOut, memAddr;
  logic [7:0]  aOut, yOut, memWdata;
  logic [7:0]  memRdata = 8'd0;

  int total = 0;
  int bad = 0;

  // results of the last command
  int          nRe, nWe, busyCycles;
  logic        sawA, sawY;
  logic [15:0] reAddr, weAddr;
  logic [7:0]  weData, gotA, gotY;

  always #2 clk = ~clk;

  altbank_ptr_unit u_altbank_ptr_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .accIn(accIn), .yIn(yIn), .offsetIn(offsetIn), .busy(busy),
    .ptrOut(ptrOut), .aOut(aOut), .aWe(aWe), .yOut(yOut), .yWe(yWe),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  function automatic logic [7:0] romByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // synchronous memory model, one-cycle read latency
  always @(posedge clk) if (memRe) memRdata <= romByte(memAddr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] a,
                       input logic [7:0] y, input logic [7:0] off);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; accIn = a; yIn = y; offsetIn = off;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic observe();
    nRe = 0; nWe = 0; busyCycles = 0; sawA = 0; sawY = 0;
    for (int i = 0; i < 10; i++) begin
      if (memRe) begin nRe++; reAddr = memAddr; end
      if (memWe) begin nWe++; weAddr = memAddr; weData = memWdata; end
      if (aWe) begin sawA = 1; gotA = aOut; end
      if (yWe) begin sawY = 1; gotY = yOut; end
      if (!busy) break;
      busyCycles++;
      @(negedge clk);
    end
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [7:0] a,
                        input logic [7:0] y, input logic [7:0] off);
    issue(op, a, y, off);
    observe();
  endtask

  task automatic setPtr(input logic [15:0] p);
    runCmd(2'd2, p[15:8], p[7:0], 8'd0);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] base, exp16, prev;
    logic [15:0] bases [3];
    int wrBefore;
    bases[0] = 16'h0000; bases[1] = 16'hFFF0; bases[2] = 16'h7F80;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptrOut == 16'h0000, "R1 ptr", ptrOut, 0);
    chk(!busy && !memRe && !memWe && !aWe && !yWe, "R1 strobes",
        {busy, memRe, memWe, aWe, yWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ptrOut == 16'h0000, "R1 ptr after release", ptrOut, 0);

    // R5 exchange: old pointer returned, new from A:Y
    runCmd(2'd2, 8'h12, 8'h34, 8'd0);
    chk(ptrOut == 16'h1234, "R5 new ptr", ptrOut, 16'h1234);
    chk(sawA && sawY && gotA == 8'h00 && gotY == 8'h00, "R5 old value",
        {gotA, gotY}, 0);
    chk(busyCycles == 0, "R8 exchange not busy", busyCycles, 0);
    runCmd(2'd2, 8'hAB, 8'hCD, 8'd0);
    chk(gotA == 8'h12 && gotY == 8'h34, "R5 return high/low", {gotA, gotY}, 16'h1234);
    chk(ptrOut == 16'hABCD, "R5 second ptr", ptrOut, 16'hABCD);

    // R6 offset sweep over all displacements from three bases
    for (int b = 0; b < 3; b++) begin
      for (int o = 0; o < 256; o++) begin
        base = bases[b];
        setPtr(base);
        runCmd(2'd3, 8'd0, 8'd0, 8'(o));
        exp16 = base + 16'($signed(8'(o)));
        chk(ptrOut == exp16, "R6 offset", ptrOut, exp16);
        chk(busyCycles == 0, "R8 offset not busy", busyCycles, 0);
      end
    end

    // R2 loads, sequential, including the wrap (R7)
    setPtr(16'hFFFC);
    for (int i = 0; i < 8; i++) begin
      prev = ptrOut;
      runCmd(2'd0, 8'd0, 8'd0, 8'd0);
      chk(nRe == 1 && reAddr == prev, "R2 read address", reAddr, prev);
      chk(sawA && !sawY && gotA == romByte(prev), "R2 loaded byte", gotA, romByte(prev));
      chk(busyCycles == 2, "R8 load busy length", busyCycles, 2);
      chk(ptrOut == 16'(prev + 1), "R7 step/wrap after load", ptrOut, 16'(prev + 1));
    end

    // R3/R4 stores straddling the read-only boundary
    setPtr(16'hBFFC);
    for (int i = 0; i < 8; i++) begin
      prev = ptrOut;
      runCmd(2'd1, 8'(8'h90 + i), 8'd0, 8'd0);
      if (prev < 16'hC000) begin
        chk(nWe == 1 && weAddr == prev && weData == 8'(8'h90 + i), "R3 store",
            {weAddr, weData}, {prev, 8'(8'h90 + i)});
      end else begin
        chk(nWe == 0, "R4 read-only store dropped", nWe, 0);
      end
      chk(nRe == 0, "R9 no read on store", nRe, 0);
      chk(busyCycles == 1, "R8 store busy length", busyCycles, 1);
      chk(ptrOut == 16'(prev + 1), "R3 R4 ptr advance", ptrOut, 16'(prev + 1));
    end
    // store wrap at 0xFFFF, read-only region
    setPtr(16'hFFFF);
    runCmd(2'd1, 8'h77, 8'd0, 8'd0);
    chk(nWe == 0 && ptrOut == 16'h0000, "R7 R4 store wrap", ptrOut, 0);

    // R8 command offered while a load is busy is ignored
    setPtr(16'h2000);
    issue(2'd0, 8'd0, 8'd0, 8'd0);
    chk(busy == 1'b1, "R8 busy after load", busy, 1);
    cmdValid = 1'b1; cmdOp = 2'd3; offsetIn = 8'h10;
    @(negedge clk);
    cmdValid = 1'b0;
    observe();
    chk(ptrOut == 16'h2001, "R8 ignored offset", ptrOut, 16'h2001);
    chk(sawA && gotA == romByte(16'h2000), "R8 load intact", gotA, romByte(16'h2000));
    @(negedge clk);
    chk(ptrOut == 16'h2001 && !busy, "R8 no late effect", ptrOut, 16'h2001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule